// File: doc/BRIEF.md
# Interleaved Page Stream Sequencer

This block drives the byte-level reads of one flash page whose columns interleave data and spare areas: each data segment (512 bytes by default) is followed at once by its spare segment (16 bytes by default), and the pair repeats along a single column axis. After the page read command has been issued elsewhere, a requester starts the sequencer with the number of data bytes and the number of spare bytes it wants. The sequencer then walks the segments in order. It emits one read request per byte, each tagged as data or spare and carrying its column.

The sequencer keeps two columns. The current column is where the flash read pointer sits. The wanted column is where the next segment begins. When the requester wants fewer bytes than a segment holds, or none at all from one kind of segment, the two columns drift apart. Before reading the next segment, the sequencer then issues a column-seek request so the skipped bytes are never clocked out. A seek that reports an error, or one that does not finish within a bounded number of cycles, aborts the page with an error flag.

Top module: `ilv_page_seq`

## Requirements
- R1: After reset, and while idle, busy_o, done_o, err_o, rd_req_o and seek_req_o are all low.
- R2: In a data phase, the block reads min(DSEG, remaining data count) bytes. Each read is a rd_req_o with rd_spare_o=0, and the reads fall on consecutive columns. The column advances by one on each cycle where rd_req_o and rd_gnt_i are both high.
- R3: In a spare phase, the block reads min(SSEG, remaining spare count) bytes. Each read has rd_spare_o=1 and the reads fall on consecutive columns.
- R4: The wanted column starts at 0. It advances by DSEG after every data phase and by SSEG after every spare phase, whether or not any bytes were read. Segment pair k therefore places data at column k*(DSEG+SSEG) and spare at k*(DSEG+SSEG)+DSEG.
- R5: Before a segment is read, if the wanted column differs from the current column, seek_req_o is raised with seek_col_o equal to the wanted column. Both stay stable until seek_done_i. The next read is then at that column. No seek is issued when the two columns are equal.
- R6: A data count of zero skips every data phase, and a spare count of zero skips every spare phase. When both counts are zero, done_o follows the start with no read or seek request.
- R7: The sequence ends once both remaining counts are zero. done_o is then a one-cycle pulse with err_o low.
- R8: seek_err_i during a seek aborts the page. done_o and err_o pulse together, and no further read or seek request follows.
- R9: If seek_done_i does not arrive, seek_req_o stays high for exactly SEEK_TMO cycles. The page then aborts as in R8.
- R10: start_i is ignored while busy_o is high.
- R11: rd_req_o and seek_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page walk (sampled when idle) |
| data_cnt_i | input | CNT_W | Data bytes wanted |
| spare_cnt_i | input | CNT_W | Spare bytes wanted |
| busy_o | output | 1 | A page walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Walk aborted; valid with done_o |
| seek_req_o | output | 1 | Column seek request |
| seek_col_o | output | COL_W | Target column of the seek |
| seek_done_i | input | 1 | Seek finished |
| seek_err_i | input | 1 | Seek failed |
| rd_req_o | output | 1 | Byte read request |
| rd_spare_o | output | 1 | Read is a spare byte (1) or data byte (0) |
| rd_col_o | output | COL_W | Column of the byte being read |
| rd_gnt_i | input | 1 | Read request accepted this cycle |

## Verification
On every cycle, the assertions check three things. Read and seek requests are mutually exclusive. A seek holds its column until it is answered and lands the next read on that column. Reads within one segment step the column by one. They also check that the end pulse lasts one cycle and that the error flag never appears without it, and they guard the remaining-byte counters against underflow. Some properties need a whole page to show, and only the bench's sweeps over every data and spare count of a reduced configuration can exercise them. These are the full order of seeks, data reads and spare reads, the wanted-column arithmetic across phases that were skipped, the exact abort timing, and the fact that a start is ignored mid-walk.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_SEEK, ST_READ} ilv_state_e;
  typedef enum logic {PH_DATA = 1'b0, PH_SPARE = 1'b1} ilv_phase_e;
endpackage

// File: rtl/ilv_rem_ctr.sv
module ilv_rem_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o); // R6
endmodule

// File: rtl/ilv_col_track.sv
module ilv_col_track #(
  parameter int unsigned COL_W = 16,
  parameter int unsigned DSEG  = 512,
  parameter int unsigned SSEG  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic             spare_ph_i,
  input  logic             seek_ok_i,
  input  logic             rd_inc_i,
  output logic [COL_W-1:0] want_o,
  output logic [COL_W-1:0] at_o,
  output logic             mismatch_o
);
  localparam logic [COL_W-1:0] D_STEP = COL_W'(DSEG);
  localparam logic [COL_W-1:0] S_STEP = COL_W'(SSEG);

  logic [COL_W-1:0] want_q, at_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_q <= '0;
      at_q   <= '0;
    end else if (clear_i) begin
      want_q <= '0;
      at_q   <= '0;
    end else begin
      if (adv_i)          want_q <= want_q + (spare_ph_i ? S_STEP : D_STEP);
      if (seek_ok_i)      at_q   <= want_q;
      else if (rd_inc_i)  at_q   <= at_q + COL_W'(1);
    end
  end

  assign want_o     = want_q;
  assign at_o       = at_q;
  assign mismatch_o = (want_q != at_q);
endmodule

// File: rtl/ilv_seek_timer.sv
module ilv_seek_timer #(
  parameter int unsigned TMO = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(TMO) + 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + TW'(1);
    else            cnt_q <= '0;
  end

  assign expire_o = run_i && (cnt_q == TW'(TMO - 1));

  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < TW'(TMO))); // R9
endmodule

// File: rtl/ilv_page_seq.sv
module ilv_page_seq
  import ilv_pkg::*;
#(
  parameter int unsigned DSEG     = 512,
  parameter int unsigned SSEG     = 16,
  parameter int unsigned COL_W    = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SEEK_TMO = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic [CNT_W-1:0] spare_cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             seek_req_o,
  output logic [COL_W-1:0] seek_col_o,
  input  logic             seek_done_i,
  input  logic             seek_err_i,
  output logic             rd_req_o,
  output logic             rd_spare_o,
  output logic [COL_W-1:0] rd_col_o,
  input  logic             rd_gnt_i
);
  localparam int unsigned SEG_W = $clog2(DSEG + 1);
  localparam logic [CNT_W-1:0] D_LEN = CNT_W'(DSEG);
  localparam logic [CNT_W-1:0] S_LEN = CNT_W'(SSEG);

  ilv_state_e       state_q;
  ilv_phase_e       phase_q;
  logic [SEG_W-1:0] seg_q;
  logic             done_q, err_q;

  logic             sp_ph;
  logic [CNT_W-1:0] rem_cnt  [2];
  logic [1:0]       rem_zero;
  logic [1:0]       rem_dec;
  logic [CNT_W-1:0] rem_cur, seg_len, seg_take;
  logic             all_zero, clear, adv, rd_inc, seek_ok, tmr_expire;
  logic [COL_W-1:0] want_col, at_col;
  logic             col_mismatch;

  assign sp_ph    = (phase_q == PH_SPARE);
  assign clear    = (state_q == ST_IDLE) && start_i;
  assign rd_inc   = (state_q == ST_READ) && rd_gnt_i;
  assign seek_ok  = (state_q == ST_SEEK) && seek_done_i && !seek_err_i;
  assign all_zero = &rem_zero;
  assign rem_cur  = rem_cnt[sp_ph];
  assign seg_len  = sp_ph ? S_LEN : D_LEN;
  assign seg_take = (rem_cur < seg_len) ? rem_cur : seg_len;
  assign rem_dec  = {rd_inc && sp_ph, rd_inc && !sp_ph};
  assign adv      = ((state_q == ST_EVAL) && !all_zero && rem_zero[sp_ph]) ||
                    (rd_inc && (seg_q == SEG_W'(1)));

  // index 0 counts data bytes, index 1 spare bytes
  for (genvar g = 0; g < 2; g++) begin : g_rem
    ilv_rem_ctr #(.CNT_W(CNT_W)) u_rem (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (clear),
      .val_i  ((g == 0) ? data_cnt_i : spare_cnt_i),
      .dec_i  (rem_dec[g]),
      .cnt_o  (rem_cnt[g]),
      .zero_o (rem_zero[g])
    );
  end

  ilv_col_track #(.COL_W(COL_W), .DSEG(DSEG), .SSEG(SSEG)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .adv_i      (adv),
    .spare_ph_i (sp_ph),
    .seek_ok_i  (seek_ok),
    .rd_inc_i   (rd_inc),
    .want_o     (want_col),
    .at_o       (at_col),
    .mismatch_o (col_mismatch)
  );

  ilv_seek_timer #(.TMO(SEEK_TMO)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_SEEK),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DATA;
      seg_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_EVAL;
          phase_q <= PH_DATA;
        end
        ST_EVAL: begin
          if (all_zero) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rem_zero[sp_ph]) begin
            phase_q <= sp_ph ? PH_DATA : PH_SPARE;  // skip empty phase
          end else if (col_mismatch) begin
            state_q <= ST_SEEK;
          end else begin
            seg_q   <= SEG_W'(seg_take);
            state_q <= ST_READ;
          end
        end
        ST_SEEK: begin
          if (seek_err_i || (!seek_done_i && tmr_expire)) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (seek_done_i) begin
            state_q <= ST_EVAL;
          end
        end
        ST_READ: if (rd_gnt_i) begin
          seg_q <= seg_q - SEG_W'(1);
          if (seg_q == SEG_W'(1)) begin
            phase_q <= sp_ph ? PH_DATA : PH_SPARE;
            state_q <= ST_EVAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign seek_req_o = (state_q == ST_SEEK);
  assign seek_col_o = want_col;
  assign rd_req_o   = (state_q == ST_READ);
  assign rd_spare_o = sp_ph;
  assign rd_col_o   = at_col;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seek_req_o && rd_req_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R8
  AST_SEEK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_req_o && !seek_done_i && !seek_err_i && !tmr_expire)
      |=> (seek_req_o && $stable(seek_col_o))); // R5
  AST_SEEK_LAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_req_o && seek_done_i && !seek_err_i)
      |=> ##1 (rd_req_o && (rd_col_o == $past(seek_col_o, 2)))); // R5
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_gnt_i)
      |=> (!rd_req_o || (rd_col_o == $past(rd_col_o) + COL_W'(1)))); // R2
endmodule

// File: tb/tb_ilv_page_seq.sv
`timescale 1ns/1ps
module tb_ilv_page_seq;
  localparam int DS  = 8;
  localparam int SS  = 2;
  localparam int CW  = 8;
  localparam int NW  = 8;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NW-1:0] data_cnt_i = '0, spare_cnt_i = '0;
  logic busy_o, done_o, err_o, seek_req_o, rd_req_o, rd_spare_o;
  logic [CW-1:0] seek_col_o, rd_col_o;
  logic seek_done_i = 1'b0, seek_err_i = 1'b0, rd_gnt_i = 1'b0;

  always #10 clk = ~clk;

  ilv_page_seq #(.DSEG(DS), .SSEG(SS), .COL_W(CW), .CNT_W(NW), .SEEK_TMO(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .data_cnt_i(data_cnt_i), .spare_cnt_i(spare_cnt_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .seek_req_o(seek_req_o), .seek_col_o(seek_col_o),
    .seek_done_i(seek_done_i), .seek_err_i(seek_err_i),
    .rd_req_o(rd_req_o), .rd_spare_o(rd_spare_o), .rd_col_o(rd_col_o),
    .rd_gnt_i(rd_gnt_i)
  );

  int total = 0, bad = 0;
  int exp_kind [64], exp_col [64], exp_n;
  int got_kind [64], got_col [64], got_n;
  bit saw_done, saw_err, overlap;
  int seek_hi;
  int wd = 0;
  bit finished = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // kinds: 0 seek, 1 data byte, 2 spare byte
  task automatic push_exp(input int k, input int c);
    if (exp_n < 64) begin exp_kind[exp_n] = k; exp_col[exp_n] = c; end
    exp_n++;
  endtask

  task automatic record(input int k, input int c);
    if (got_n < 64) begin got_kind[got_n] = k; got_col[got_n] = c; end
    got_n++;
  endtask

  task automatic build_exp(input int dc, input int sc);
    int want = 0, at = 0, dl = dc, sl = sc, n;
    exp_n = 0;
    while (dl > 0 || sl > 0) begin
      if (dl > 0) begin
        if (want != at) begin push_exp(0, want); at = want; end
        n = (dl < DS) ? dl : DS;
        for (int i = 0; i < n; i++) push_exp(1, at + i);
        at += n; dl -= n;
      end
      want += DS;
      if (sl > 0) begin
        if (want != at) begin push_exp(0, want); at = want; end
        n = (sl < SS) ? sl : SS;
        for (int i = 0; i < n; i++) push_exp(2, at + i);
        at += n; sl -= n;
      end
      want += SS;
    end
  endtask

  // emode: 0 normal, 1 seek error on first seek, 2 seek never answered
  task automatic run_case(input int dc, input int sc, input int gmode, input bit mid, input int emode);
    int sd = 0;
    got_n = 0; saw_done = 0; saw_err = 0; overlap = 0; seek_hi = 0;
    @(negedge clk);
    start_i = 1'b1; data_cnt_i = NW'(dc); spare_cnt_i = NW'(sc);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (c != 0) @(negedge clk);
      if (done_o) begin saw_done = 1; saw_err = err_o; break; end
      if (rd_req_o && seek_req_o) overlap = 1;
      start_i = mid && (c == 4);
      if (mid && c == 4) begin data_cnt_i = NW'(dc + 1); spare_cnt_i = NW'(sc + 2); end
      rd_gnt_i = (gmode == 0) ? 1'b1 : ((c % 3) != 1);
      if (rd_req_o && rd_gnt_i) record(rd_spare_o ? 2 : 1, int'(rd_col_o));
      seek_done_i = 1'b0; seek_err_i = 1'b0;
      if (seek_req_o) begin
        seek_hi++;
        if (emode != 2 && sd >= gmode + 1) begin
          if (emode == 1) seek_err_i = 1'b1; else seek_done_i = 1'b1;
          record(0, int'(seek_col_o));
          sd = 0;
        end else sd++;
      end else sd = 0;
    end
    start_i = 1'b0; rd_gnt_i = 1'b0; seek_done_i = 1'b0; seek_err_i = 1'b0;
  endtask

  task automatic cmp_seq(input string rq);
    int idx = -1;
    if (got_n != exp_n) chk(0, rq, "event count", got_n, exp_n);
    else begin
      for (int i = 0; i < exp_n && i < 64; i++)
        if (idx < 0 && (got_kind[i] != exp_kind[i] || got_col[i] != exp_col[i])) idx = i;
      if (idx < 0) chk(1, rq, "sequence", 0, 0);
      else chk(0, rq, "event kind*1000+col", got_kind[idx]*1000 + got_col[idx],
               exp_kind[idx]*1000 + exp_col[idx]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !err_o && !rd_req_o && !seek_req_o, "R1", "outputs in reset",
        {busy_o, done_o, err_o, rd_req_o, seek_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o && !seek_req_o, "R1", "outputs idle after reset",
        {busy_o, done_o, rd_req_o, seek_req_o}, 0);

    // R2 R3 R4 R5 R6 R7 R11: sweep all counts over three segment pairs
    for (int dc = 0; dc <= 3 * DS; dc++)
      for (int sc = 0; sc <= 3 * SS; sc++) begin
        build_exp(dc, sc);
        run_case(dc, sc, (dc + sc) % 2, 0, 0);
        cmp_seq((dc == 0 || sc == 0) ? "R6" : "R2 R3 R4 R5");
        chk(saw_done && !saw_err, "R7", "clean done", {saw_done, saw_err}, 2);
        chk(!overlap, "R11", "req overlap", overlap, 0);
        chk(!busy_o, "R7", "idle after done", busy_o, 0);
      end

    // R10: start pulse mid-walk is ignored
    build_exp(2 * DS + 3, SS + 1);
    run_case(2 * DS + 3, SS + 1, 1, 1, 0);
    cmp_seq("R10");

    // R8: seek error aborts (3 data bytes, then seek to DS)
    build_exp(3, 2);
    run_case(3, 2, 0, 0, 1);
    chk(saw_done && saw_err, "R8", "abort flags", {saw_done, saw_err}, 3);
    chk(got_n == 4 && got_kind[3] == 0 && got_col[3] == DS, "R8", "events before abort",
        got_n, 4);
    repeat (4) begin
      @(negedge clk);
      chk(!rd_req_o && !seek_req_o && !done_o, "R8", "quiet after abort",
          {rd_req_o, seek_req_o, done_o}, 0);
    end

    // R9: unanswered seek times out
    run_case(3, 2, 0, 0, 2);
    chk(saw_done && saw_err, "R9", "timeout abort flags", {saw_done, saw_err}, 3);
    chk(seek_hi == TMO, "R9", "seek request cycles", seek_hi, TMO);

    // R4: full data and spare reads need no seek
    build_exp(2 * DS, 2 * SS);
    run_case(2 * DS, 2 * SS, 0, 0, 0);
    cmp_seq("R4");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule